// File: doc/BRIEF.md
# TDM Frame-Sync Serial Word Receiver

This block takes in a time-division-multiplexed serial stream from an external source. That source drives three wires: a serial clock, an active-high frame-sync pulse and one data line. The receiver runs on a faster system clock and oversamples all three wires through two-flop synchronizers. It detects the edges of the serial clock and of the frame sync, and it treats a rising edge of the frame sync as the start of a frame.

Starting at the first serial clock rising edge after that frame-sync rise, the receiver shifts in fixed-width words, most significant bit first. It does this only for the first `CAPTURE_SLOTS` channels of the frame and ignores the rest of the frame's bits. Each finished word appears on a parallel output as a one-cycle valid strobe. The word is zero-extended to 32 bits and tagged with its channel index.

The defaults describe a frame of eight 24-bit channels, all of which are captured. When a new frame-sync rise arrives in the middle of a frame, the word in progress is dropped and capture restarts at channel 0.

Top module: `tdm_fs_rx`

## Requirements
- R1: After reset the word valid output is low, and both the word data and channel outputs are zero until the first word completes.
- R2: Each word is assembled from `WORD_BITS` data bits sampled at serial clock rising edges. The first bit received becomes the most significant bit of the word.
- R3: The word data output is 32 bits wide. The received word sits in bits `WORD_BITS-1:0`, and every bit above it reads 0.
- R4: The first data bit of a frame is the one sampled at the first serial clock rising edge after the frame sync rises. Bits clocked while no frame is open produce no output.
- R5: Per frame, only channels 0 to `CAPTURE_SLOTS-1` are emitted. Later bits of that frame produce no output until the next frame-sync rise.
- R6: The channel output carries the index of the word within its frame. The index counts 0, 1, 2 … in arrival order and stays below `CAPTURE_SLOTS`.
- R7: Each completed word raises word valid for exactly one system clock cycle.
- R8: A frame-sync rising edge inside an open frame discards the partial word. The next word emitted is channel 0 of the new frame.
- R9: Reception is correct with the serial clock running anywhere from half the system clock rate down to slower rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the external source |
| fsync_i | input | 1 | Active-high frame-sync pulse |
| sdata_i | input | 1 | Serial data, MSB first |
| word_valid_o | output | 1 | One-cycle strobe per received word |
| word_data_o | output | 32 | Received word, zero-extended |
| word_chan_o | output | $clog2(NUM_SLOTS) | Channel index of the word |

## Verification
The assertions rely on three properties of the source:
- The serial clock stays high and low for at least one system clock each, so successive serial clock rises are at least two system cycles apart.
- Data and frame sync change only while the serial clock is low.
- The frame sync rises before the first data bit's clock edge, not together with it.

The stimulus meets all three. It drives every wire on the falling system clock edge and changes data and frame sync only in the low phase of the serial clock. Its fastest serial clock has one system cycle high and one low.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int OUT_W = 32;

  typedef struct packed {
    logic sclk;
    logic fsync;
    logic sdata;
  } line_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tdm_rx_edges.sv
module tdm_rx_edges
  import tdm_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  line_t line_i,
  output logic  sclk_rise_o,
  output logic  fs_rise_o,
  output logic  bit_o
);

  logic sclk_q;
  logic fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      sclk_q <= line_i.sclk;
      fs_q   <= line_i.fsync;
    end
  end

  assign sclk_rise_o = line_i.sclk  & ~sclk_q;
  assign fs_rise_o   = line_i.fsync & ~fs_q;
  assign bit_o       = line_i.sdata;

endmodule

// File: rtl/tdm_rx_deframer.sv
module tdm_rx_deframer
  import tdm_rx_pkg::*;
#(
  parameter int WORD_BITS     = 24,
  parameter int NUM_SLOTS     = 8,
  parameter int CAPTURE_SLOTS = 8,
  localparam int CW = idx_width(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_rise_i,
  input  logic                 fs_rise_i,
  input  logic                 bit_i,
  output logic                 emit_o,
  output logic [WORD_BITS-1:0] word_o,
  output logic [CW-1:0]        chan_o
);

  localparam int CAP_EFF = (CAPTURE_SLOTS < NUM_SLOTS) ? CAPTURE_SLOTS : NUM_SLOTS;
  localparam int BW      = idx_width(WORD_BITS);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_BITS - 1);
  localparam logic [CW-1:0] LAST_CHAN = CW'(CAP_EFF - 1);

  logic                 active_q;
  logic                 pending_q;
  logic [BW-1:0]        bit_q;
  logic [CW-1:0]        chan_q;
  logic [WORD_BITS-1:0] shift_q;

  logic start;
  logic shift_en;
  logic last_bit;

  assign start    = sclk_rise_i & (pending_q | fs_rise_i);
  assign shift_en = sclk_rise_i & active_q & ~start;
  assign last_bit = (bit_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      pending_q <= 1'b0;
      bit_q     <= '0;
      chan_q    <= '0;
      shift_q   <= '0;
    end else if (fs_rise_i && !sclk_rise_i) begin
      // new frame announced: drop any word in progress, wait for the clock edge
      pending_q <= 1'b1;
      active_q  <= 1'b0;
    end else if (start) begin
      pending_q <= 1'b0;
      active_q  <= 1'b1;
      chan_q    <= '0;
      bit_q     <= BW'(1);
      shift_q   <= {{(WORD_BITS-1){1'b0}}, bit_i};
    end else if (shift_en) begin
      shift_q <= {shift_q[WORD_BITS-2:0], bit_i};
      if (last_bit) begin
        bit_q <= '0;
        if (chan_q == LAST_CHAN) active_q <= 1'b0;
        else                     chan_q   <= chan_q + CW'(1);
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

  assign emit_o = shift_en & last_bit;
  assign word_o = {shift_q[WORD_BITS-2:0], bit_i};
  assign chan_o = chan_q;

  AST_EMIT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    emit_o |-> !pending_q); // R4

  AST_FS_RESTART: assert property (@(posedge clk) disable iff (rst)
    fs_rise_i |=> (pending_q || (active_q && chan_q == '0 && bit_q == BW'(1)))); // R8

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (rst)
    (emit_o && chan_q != LAST_CHAN && !fs_rise_i) |=> (chan_q == $past(chan_q) + CW'(1))); // R6

endmodule

// File: rtl/tdm_rx_out.sv
module tdm_rx_out
  import tdm_rx_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int CW        = 3,
  parameter int CAP       = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 emit_i,
  input  logic [WORD_BITS-1:0] word_i,
  input  logic [CW-1:0]        chan_i,
  output logic                 valid_o,
  output logic [OUT_W-1:0]     data_o,
  output logic [CW-1:0]        chan_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      chan_o  <= '0;
    end else begin
      valid_o <= emit_i;
      if (emit_i) begin
        data_o <= OUT_W'(word_i);
        chan_o <= chan_i;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R7

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (int'(chan_o) < CAP)); // R6

  generate
    if (WORD_BITS < OUT_W) begin : g_pad_chk
      AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (data_o[OUT_W-1:WORD_BITS] == '0)); // R3
    end
  endgenerate

endmodule

// File: rtl/tdm_fs_rx.sv
module tdm_fs_rx
  import tdm_rx_pkg::*;
#(
  parameter int WORD_BITS     = 24,
  parameter int NUM_SLOTS     = 8,
  parameter int CAPTURE_SLOTS = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int CW = idx_width(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             fsync_i,
  input  logic             sdata_i,
  output logic             word_valid_o,
  output logic [OUT_W-1:0] word_data_o,
  output logic [CW-1:0]    word_chan_o
);

  localparam int CAP_EFF = (CAPTURE_SLOTS < NUM_SLOTS) ? CAPTURE_SLOTS : NUM_SLOTS;

  line_t raw_line;
  line_t sync_line;
  logic  sclk_rise;
  logic  fs_rise;
  logic  rx_bit;
  logic  emit;
  logic [WORD_BITS-1:0] word;
  logic [CW-1:0]        chan;

  assign raw_line = '{sclk: sclk_i, fsync: fsync_i, sdata: sdata_i};

  tdm_rx_sync #(.WIDTH($bits(line_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_line),
    .sync_o  (sync_line)
  );

  tdm_rx_edges u_edges (
    .clk         (clk),
    .rst         (rst),
    .line_i      (sync_line),
    .sclk_rise_o (sclk_rise),
    .fs_rise_o   (fs_rise),
    .bit_o       (rx_bit)
  );

  tdm_rx_deframer #(
    .WORD_BITS     (WORD_BITS),
    .NUM_SLOTS     (NUM_SLOTS),
    .CAPTURE_SLOTS (CAPTURE_SLOTS)
  ) u_deframer (
    .clk         (clk),
    .rst         (rst),
    .sclk_rise_i (sclk_rise),
    .fs_rise_i   (fs_rise),
    .bit_i       (rx_bit),
    .emit_o      (emit),
    .word_o      (word),
    .chan_o      (chan)
  );

  tdm_rx_out #(.WORD_BITS(WORD_BITS), .CW(CW), .CAP(CAP_EFF)) u_out (
    .clk     (clk),
    .rst     (rst),
    .emit_i  (emit),
    .word_i  (word),
    .chan_i  (chan),
    .valid_o (word_valid_o),
    .data_o  (word_data_o),
    .chan_o  (word_chan_o)
  );

endmodule

// File: tb/test_tdm_fs_rx.sv
module test_tdm_fs_rx;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 24;
  localparam int SLOTS      = 8;
  localparam int CAP_A      = 8;
  localparam int CAP_B      = 3;
  localparam int CW         = 3;
  localparam int WD_CYCLES  = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic fsync = 1'b0;
  logic sdata = 1'b0;

  logic          val_a, val_b;
  logic [31:0]   dat_a, dat_b;
  logic [CW-1:0] ch_a, ch_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_d_a[$];
  int          exp_c_a[$];
  logic [31:0] exp_d_b[$];
  int          exp_c_b[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_fs_rx #(.WORD_BITS(W), .NUM_SLOTS(SLOTS), .CAPTURE_SLOTS(CAP_A)) i_tdm_fs_rx (
    .clk(clk), .rst(rst), .sclk_i(sclk), .fsync_i(fsync), .sdata_i(sdata),
    .word_valid_o(val_a), .word_data_o(dat_a), .word_chan_o(ch_a)
  );

  tdm_fs_rx #(.WORD_BITS(W), .NUM_SLOTS(SLOTS), .CAPTURE_SLOTS(CAP_B)) i_tdm_fs_rx_part (
    .clk(clk), .rst(rst), .sclk_i(sclk), .fsync_i(fsync), .sdata_i(sdata),
    .word_valid_o(val_b), .word_data_o(dat_b), .word_chan_o(ch_b)
  );

  function automatic logic [W-1:0] pat(input int f, input int c);
    if (f == 4) begin
      case (c)
        0: return 24'hFFFFFF;
        1: return 24'h000000;
        2: return 24'hAAAAAA;
        3: return 24'h050505;
        default: return 24'hFFFFFF;
      endcase
    end
    return W'(32'h00C3A51E ^ (f * 32'h0001357B) ^ (c * 32'h000F1E35) ^ (c << 20));
  endfunction

  task automatic idle_bits(input int n, input int hp);
    for (int k = 0; k < n; k++) begin
      sclk = 1'b0; fsync = 1'b0; sdata = k[0] ^ k[2];
      repeat (hp) @(negedge clk);
      sclk = 1'b1;
      repeat (hp) @(negedge clk);
    end
  endtask

  // Drives nbits of frame f; queues every completed word the requirements say must appear.
  task automatic send_frame(input int f, input int nbits, input int hp);
    for (int k = 0; k < nbits; k++) begin
      int c;
      int b;
      logic [W-1:0] w;
      c = k / W;
      b = W - 1 - (k % W);
      w = pat(f, c);
      sclk = 1'b0; fsync = (k < 2); sdata = w[b];
      repeat (hp) @(negedge clk);
      if (b == 0) begin
        if (c < CAP_A) begin exp_d_a.push_back({8'h00, w}); exp_c_a.push_back(c); end
        if (c < CAP_B) begin exp_d_b.push_back({8'h00, w}); exp_c_b.push_back(c); end
      end
      sclk = 1'b1;
      repeat (hp) @(negedge clk);
    end
  endtask

  // scoreboard monitor
  logic prev_a = 1'b0, prev_b = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (val_a) begin
        checks++;
        if (exp_d_a.size() == 0) begin
          failures++;
          $display("FAIL R4 R5 dut A unexpected word act=%h chan=%0d exp=none", dat_a, ch_a);
        end else begin
          logic [31:0] ed;
          int ec;
          ed = exp_d_a.pop_front();
          ec = exp_c_a.pop_front();
          if (dat_a !== ed || int'(ch_a) != ec) begin
            failures++;
            $display("FAIL R2 R3 R6 R8 R9 dut A act=%h/%0d exp=%h/%0d", dat_a, ch_a, ed, ec);
          end
        end
        checks++;
        if (prev_a) begin
          failures++;
          $display("FAIL R7 dut A valid act=2 cycles exp=1 cycle");
        end
      end
      if (val_b) begin
        checks++;
        if (exp_d_b.size() == 0) begin
          failures++;
          $display("FAIL R5 dut B unexpected word act=%h chan=%0d exp=none", dat_b, ch_b);
        end else begin
          logic [31:0] ed;
          int ec;
          ed = exp_d_b.pop_front();
          ec = exp_c_b.pop_front();
          if (dat_b !== ed || int'(ch_b) != ec) begin
            failures++;
            $display("FAIL R5 R6 dut B act=%h/%0d exp=%h/%0d", dat_b, ch_b, ed, ec);
          end
        end
        checks++;
        if (prev_b) begin
          failures++;
          $display("FAIL R7 dut B valid act=2 cycles exp=1 cycle");
        end
      end
      prev_a = val_a;
      prev_b = val_b;
    end
  end

  task automatic expect_drained(input string tag);
    checks++;
    if (exp_d_a.size() != 0) begin
      failures++;
      $display("FAIL %s dut A missing words act=0 exp=%0d", tag, exp_d_a.size());
    end
    checks++;
    if (exp_d_b.size() != 0) begin
      failures++;
      $display("FAIL %s dut B missing words act=0 exp=%0d", tag, exp_d_b.size());
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (val_a !== 1'b0 || dat_a !== 32'h0 || ch_a !== '0) begin
      failures++;
      $display("FAIL R1 dut A act=%b/%h/%0d exp=0/0/0", val_a, dat_a, ch_a);
    end
    checks++;
    if (val_b !== 1'b0 || dat_b !== 32'h0 || ch_b !== '0) begin
      failures++;
      $display("FAIL R1 dut B act=%b/%h/%0d exp=0/0/0", val_b, dat_b, ch_b);
    end

    // R4: clocked bits with no frame open give nothing
    idle_bits(30, 2);
    repeat (10) @(negedge clk);
    expect_drained("R4");
    // R2 R3 R5 R6: full frame, slow clock
    send_frame(0, SLOTS * W, 2);
    idle_bits(12, 2);
    repeat (10) @(negedge clk);
    expect_drained("R5");
    // R9: half system rate
    send_frame(1, SLOTS * W, 1);
    idle_bits(6, 1);
    // R8: restart in the middle of channel 2
    send_frame(2, 2 * W + 10, 2);
    send_frame(3, SLOTS * W, 2);
    idle_bits(4, 3);
    // corner patterns, slower clock
    send_frame(4, SLOTS * W, 3);
    idle_bits(8, 2);
    repeat (20) @(negedge clk);
    expect_drained("R8");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule